// File: doc/BRIEF.md
# Baseline Tracker and Pulse Trigger

This block is the front end of one detector channel. It takes unsigned 12-bit converter samples, one on every clock, and keeps two running estimates. The first is the DC level of the channel. The second is the typical size of the noise around that level. The block subtracts the level estimate from each sample and drives the signed result out. A detect strobe marks the output sample on which a pulse is recognised.

The block declares a pulse when two corrected samples in a row are both above a noise-derived threshold plus a programmable margin. Both estimators freeze while a sample is above the threshold or a hold-off is running, so that pulse energy does not bias them. After reset there is a settling period during which the estimators learn freely and no detect is issued. After each detect, a programmable hold-off keeps the trigger silent for a number of samples.

A downstream fitting stage uses the corrected stream and the strobe. Each instance serves exactly one channel.

Top module: `baseline_trig`

## Requirements
- R1: `corr_sample` equals the sample from the previous clock minus the baseline held before that clock. The baseline is the level accumulator shifted right by `EMA_SHIFT` (default 6), and the result is signed and 13 bits wide.
- R2: The first sample after reset loads the level accumulator directly with sample·2^6. Its own corrected output is the raw sample, because the baseline is still 0. The second sample's corrected output is the second sample minus the first.
- R3: When updating, the level accumulator becomes acc − floor(acc/64) + sample, so the baseline follows slow drift of the input.
- R4: The threshold is floor(dev/16) + `margin`, where dev is a second accumulator updated as dev − floor(dev/64) + |corrected sample|; this makes it four times the mean absolute deviation. A sample counts as above only when its corrected value is strictly greater than this threshold.
- R5: A detect needs the current sample and the previous sample to both be above. A single above sample never produces a detect.
- R6: `detect` is high in the same cycle as the corrected value of the second above sample, and stays high for exactly one cycle per firing.
- R7: After a detect, the next `holdoff_len` samples cannot fire; the typical setting is 32. When `holdoff_len` is 0, back-to-back detects on consecutive samples are allowed.
- R8: Samples 0 to 255 after reset never fire, and during them both accumulators update on every sample except the first.
- R9: After the settling period, both accumulators hold their value on any sample that is above, and on any sample taken while a hold-off is counting.
- R10: While reset is asserted, `corr_sample` is 0 and `detect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_sample | input | 12 | Unsigned converter sample |
| margin | input | 8 | Constant added on top of the learned noise threshold |
| holdoff_len | input | 8 | Number of samples blocked after each detect |
| corr_sample | output | 13 | Signed baseline-corrected sample, one clock of latency |
| detect | output | 1 | Pulse-detect strobe aligned to `corr_sample` |

## Verification
The assertions assume that `margin` and `holdoff_len` stay constant from the sample that starts a detect until its hold-off has expired. This is because the hold-off gap and the two-above check are judged against the values present when the strobe is seen. The stimulus changes these controls only during quiet stretches that follow a completed hold-off. It keeps pulses far above the threshold or far below it, and it moves the level only as a slow ramp that stays well under the threshold. A level step larger than the threshold would be treated as a pulse that never ends, and the bench keeps away from that case.

// File: rtl/baseline_trig_pkg.sv
package baseline_trig_pkg;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/baseline_ema.sv
module baseline_ema #(
   parameter int SAMPLE_W        = 12,
   parameter int EMA_SHIFT       = 6,
   parameter bit INIT_FROM_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                upd,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [SAMPLE_W-1:0] baseline
);
   localparam int ACC_W = SAMPLE_W + EMA_SHIFT;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_step;
   logic [ACC_W-1:0] acc_seed;

   // leaky integrator: acc keeps baseline scaled by 2^EMA_SHIFT
   assign acc_step = acc_q - (acc_q >> EMA_SHIFT) + ACC_W'(sample);

   generate
      if (INIT_FROM_FIRST) begin : g_seed_first
         assign acc_seed = {sample, {EMA_SHIFT{1'b0}}};
      end else begin : g_seed_zero
         assign acc_seed = acc_step;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (load) begin
         acc_q <= acc_seed;
      end else if (upd) begin
         acc_q <= acc_step;
      end
   end

   assign baseline = acc_q[ACC_W-1:EMA_SHIFT];

endmodule

// File: rtl/noise_est.sv
module noise_est #(
   parameter int SAMPLE_W      = 12,
   parameter int EMA_SHIFT     = 6,
   parameter int THR_MULT_LOG2 = 2,
   localparam int THR_W        = SAMPLE_W + THR_MULT_LOG2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd,
   input  logic signed [SAMPLE_W:0]   corr,
   output logic [THR_W-1:0]           thr
);
   localparam int ACC_W = SAMPLE_W + EMA_SHIFT;

   logic [SAMPLE_W:0] mag;
   logic [ACC_W-1:0]  dev_q;
   logic [ACC_W-1:0]  dev_step;

   assign mag      = corr[SAMPLE_W] ? $unsigned(-corr) : $unsigned(corr);
   assign dev_step = dev_q - (dev_q >> EMA_SHIFT) + ACC_W'(mag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_q <= '0;
      end else if (upd) begin
         dev_q <= dev_step;
      end
   end

   // scale mean deviation by 2^THR_MULT_LOG2 and drop the fraction bits
   generate
      if (THR_MULT_LOG2 < EMA_SHIFT) begin : g_thr_down
         assign thr = dev_q[ACC_W-1:EMA_SHIFT-THR_MULT_LOG2];
      end else if (THR_MULT_LOG2 == EMA_SHIFT) begin : g_thr_same
         assign thr = dev_q;
      end else begin : g_thr_up
         assign thr = {dev_q, {(THR_MULT_LOG2-EMA_SHIFT){1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
   import baseline_trig_pkg::*;
#(
   parameter int SETTLE_LEN = 256,
   parameter int HOLD_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              above,
   input  logic [HOLD_W-1:0] holdoff_len,
   output logic              load,
   output logic              upd,
   output logic              fire
);
   localparam int CNT_W = cnt_width(SETTLE_LEN);

   logic              primed_q;
   logic              prev_q;
   logic [HOLD_W-1:0] hold_q;
   logic              settling;
   logic              hold_idle;

   generate
      if (SETTLE_LEN > 0) begin : g_settle
         logic [CNT_W-1:0] settle_q;
         assign settling = (settle_q < CNT_W'(SETTLE_LEN));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               settle_q <= '0;
            end else if (settling) begin
               settle_q <= settle_q + 1'b1;
            end
         end
      end else begin : g_no_settle
         assign settling = 1'b0;
      end
   endgenerate

   assign hold_idle = (hold_q == '0);
   assign load      = !primed_q;
   assign fire      = !settling && hold_idle && above && prev_q;
   assign upd       = primed_q && (settling || (!above && hold_idle));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q <= 1'b0;
         prev_q   <= 1'b0;
         hold_q   <= '0;
      end else begin
         primed_q <= 1'b1;
         prev_q   <= above;
         if (fire) begin
            hold_q <= holdoff_len;
         end else if (!hold_idle) begin
            hold_q <= hold_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/baseline_trig.sv
module baseline_trig
   import baseline_trig_pkg::*;
#(
   parameter int SAMPLE_W      = 12,
   parameter int EMA_SHIFT     = 6,
   parameter int THR_MULT_LOG2 = 2,
   parameter int MARGIN_W      = 8,
   parameter int HOLD_W        = 8,
   parameter int SETTLE_LEN    = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SAMPLE_W-1:0]        adc_sample,
   input  logic [MARGIN_W-1:0]        margin,
   input  logic [HOLD_W-1:0]          holdoff_len,
   output logic signed [SAMPLE_W:0]   corr_sample,
   output logic                       detect
);
   localparam int THR_W     = SAMPLE_W + THR_MULT_LOG2;
   localparam int THR_EFF_W = imax(THR_W, MARGIN_W) + 1;
   localparam int CMP_W     = imax(SAMPLE_W, THR_EFF_W);

   generate
      if (SAMPLE_W < 2)       begin : g_bad_sw  $error("SAMPLE_W must be at least 2");  end
      if (EMA_SHIFT < 1)      begin : g_bad_ema $error("EMA_SHIFT must be at least 1"); end
      if (THR_MULT_LOG2 < 0)  begin : g_bad_tm  $error("THR_MULT_LOG2 must not be negative"); end
      if (MARGIN_W < 1)       begin : g_bad_mw  $error("MARGIN_W must be at least 1");  end
      if (HOLD_W < 1)         begin : g_bad_hw  $error("HOLD_W must be at least 1");    end
      if (SETTLE_LEN < 0)     begin : g_bad_st  $error("SETTLE_LEN must not be negative"); end
   endgenerate

   logic [SAMPLE_W-1:0]      baseline;
   logic [THR_W-1:0]         thr;
   logic [THR_EFF_W-1:0]     thr_eff;
   logic signed [SAMPLE_W:0] corr_w;
   logic [CMP_W-1:0]         corr_mag;
   logic                     above;
   logic                     load;
   logic                     upd;
   logic                     fire;

   assign corr_w   = $signed({1'b0, adc_sample}) - $signed({1'b0, baseline});
   assign thr_eff  = THR_EFF_W'(thr) + THR_EFF_W'(margin);
   assign corr_mag = CMP_W'(corr_w[SAMPLE_W-1:0]);
   assign above    = !corr_w[SAMPLE_W] && (corr_mag > CMP_W'(thr_eff));

   baseline_ema #(
      .SAMPLE_W       (SAMPLE_W),
      .EMA_SHIFT      (EMA_SHIFT),
      .INIT_FROM_FIRST(1'b1)
   ) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .upd     (upd),
      .sample  (adc_sample),
      .baseline(baseline)
   );

   noise_est #(
      .SAMPLE_W     (SAMPLE_W),
      .EMA_SHIFT    (EMA_SHIFT),
      .THR_MULT_LOG2(THR_MULT_LOG2)
   ) u_noise (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (upd),
      .corr (corr_w),
      .thr  (thr)
   );

   trig_ctrl #(
      .SETTLE_LEN(SETTLE_LEN),
      .HOLD_W    (HOLD_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .above      (above),
      .holdoff_len(holdoff_len),
      .load       (load),
      .upd        (upd),
      .fire       (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_sample <= '0;
         detect      <= 1'b0;
      end else begin
         corr_sample <= corr_w;
         detect      <= fire;
      end
   end

endmodule

// File: rtl/baseline_trig_chk.sv
module baseline_trig_chk
   import baseline_trig_pkg::*;
#(
   parameter int SAMPLE_W   = 12,
   parameter int MARGIN_W   = 8,
   parameter int HOLD_W     = 8,
   parameter int SETTLE_LEN = 256
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [MARGIN_W-1:0]      margin,
   input logic [HOLD_W-1:0]        holdoff_len,
   input logic signed [SAMPLE_W:0] corr_sample,
   input logic                     detect
);
   localparam int SEEN_W = cnt_width(SETTLE_LEN + 1) + 1;
   localparam int GAP_W  = HOLD_W + 1;

   logic [SEEN_W-1:0]       seen_q;
   logic [GAP_W-1:0]        gap_q;
   logic [HOLD_W-1:0]       held_q;
   logic                    ever_q;
   logic signed [MARGIN_W:0] margin_s;

   assign margin_s = $signed({1'b0, margin});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         gap_q  <= '0;
         held_q <= '0;
         ever_q <= 1'b0;
      end else begin
         if (seen_q <= SEEN_W'(SETTLE_LEN)) seen_q <= seen_q + 1'b1;
         if (detect) begin
            gap_q  <= '0;
            held_q <= holdoff_len;
            ever_q <= 1'b1;
         end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   AST_SETTLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      detect |-> (seen_q > SEEN_W'(SETTLE_LEN)))
      else $error("detect during settling"); // R8

   AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (detect && ever_q) |-> (gap_q >= GAP_W'(held_q)))
      else $error("detect inside hold-off"); // R7

   AST_TWO_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      detect |-> ((corr_sample > margin_s) && ($past(corr_sample) > margin_s)))
      else $error("detect without two samples over margin"); // R5

   AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({detect, corr_sample}))
      else $error("unknown output"); // R1

endmodule

bind baseline_trig baseline_trig_chk #(
   .SAMPLE_W  (SAMPLE_W),
   .MARGIN_W  (MARGIN_W),
   .HOLD_W    (HOLD_W),
   .SETTLE_LEN(SETTLE_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .margin     (margin),
   .holdoff_len(holdoff_len),
   .corr_sample(corr_sample),
   .detect     (detect)
);

// File: tb/baseline_trig_tb_top.sv
module baseline_trig_tb_top;
   localparam int CLK_PERIOD = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [11:0]        adc_sample = '0;
   logic [7:0]         margin = 8'd8;
   logic [7:0]         holdoff_len = 8'd32;
   logic signed [12:0] corr_sample;
   logic               detect;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // behavioural reference state
   int m_acc = 0, m_dev = 0, m_cnt = 0, m_hold = 0;
   bit m_primed = 0, m_prev = 0;
   int unsigned seed = 32'd12345;
   int level = 1000;
   int phase_det = 0;
   int last_corr = 0;
   bit last_det = 0;

   baseline_trig dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .adc_sample (adc_sample),
      .margin     (margin),
      .holdoff_len(holdoff_len),
      .corr_sample(corr_sample),
      .detect     (detect)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int noise();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) % 7) - 3;
   endfunction

   // present one sample, advance the model, compare after the edge
   task automatic step(input int s, input string req);
      int base, corr, thr, mag;
      bit ab, settling, fire, upd;
      adc_sample = 12'(s);
      base     = m_acc / 64;
      corr     = s - base;
      thr      = m_dev / 16 + int'(margin);
      ab       = corr > thr;
      settling = m_cnt < 256;
      fire     = !settling && m_hold == 0 && ab && m_prev;
      upd      = m_primed && (settling || (!ab && m_hold == 0));
      mag      = (corr < 0) ? -corr : corr;
      if (!m_primed) begin
         m_acc = s * 64;
      end else if (upd) begin
         m_acc = m_acc - m_acc / 64 + s;
         m_dev = m_dev - m_dev / 64 + mag;
      end
      m_primed = 1;
      if (settling) m_cnt++;
      if (fire) m_hold = int'(holdoff_len);
      else if (m_hold > 0) m_hold--;
      m_prev = ab;
      @(negedge clk);
      chk(int'(corr_sample) == corr, "R1", int'(corr_sample), corr);
      chk(detect == fire, req, int'(detect), int'(fire));
      last_corr = int'(corr_sample);
      last_det  = detect;
      if (detect) phase_det++;
   endtask

   task automatic quiet(input int n, input string req);
      for (int i = 0; i < n; i++) step(level + noise(), req);
   endtask

   task automatic pulse(input int n, input int amp, input string req);
      for (int i = 0; i < n; i++) step(level + amp + noise(), req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(corr_sample == 0, "R10", int'(corr_sample), 0);
      chk(detect == 0, "R10", int'(detect), 0);
      rst_n = 1'b1;

      // R2: seeding from the first sample
      step(1000, "R2");
      chk(last_corr == 1000, "R2", last_corr, 1000);
      step(1003, "R2");
      chk(last_corr == 3, "R2", last_corr, 3);

      // R8: settling window, pulse inside must not fire
      phase_det = 0;
      quiet(100, "R8");
      pulse(2, 200, "R8");
      quiet(152, "R8");
      chk(phase_det == 0, "R8", phase_det, 0);

      quiet(100, "R9");

      // R5/R6: two-sample pulse, detect on the second
      phase_det = 0;
      step(level + 200, "R6");
      chk(last_det == 0, "R6", int'(last_det), 0);
      step(level + 200, "R6");
      chk(last_det == 1, "R6", int'(last_det), 1);
      quiet(40, "R5");
      chk(phase_det == 1, "R5", phase_det, 1);

      // R5: isolated spike
      phase_det = 0;
      pulse(1, 300, "R5");
      quiet(40, "R5");
      chk(phase_det == 0, "R5", phase_det, 0);

      // R4: margin raises the trigger level
      margin = 8'd200;
      phase_det = 0;
      pulse(2, 150, "R4");
      quiet(40, "R4");
      chk(phase_det == 0, "R4", phase_det, 0);
      margin = 8'd8;
      quiet(5, "R4");
      phase_det = 0;
      pulse(2, 150, "R4");
      quiet(40, "R4");
      chk(phase_det == 1, "R4", phase_det, 1);

      // R7/R9: long pulse with hold-off 32
      phase_det = 0;
      pulse(40, 200, "R7");
      chk(phase_det == 2, "R7", phase_det, 2);
      step(level, "R9");
      chk(last_corr >= -6 && last_corr <= 6, "R9", last_corr, 0);
      quiet(60, "R9");

      // R7: zero hold-off allows back-to-back detects
      holdoff_len = 8'd0;
      quiet(3, "R7");
      phase_det = 0;
      pulse(4, 200, "R7");
      quiet(40, "R7");
      chk(phase_det == 3, "R7", phase_det, 3);
      holdoff_len = 8'd32;

      // R3: slow drift is tracked, no triggers
      phase_det = 0;
      for (int k = 0; k < 50; k++) begin
         level++;
         quiet(16, "R3");
      end
      quiet(300, "R3");
      chk(phase_det == 0, "R3", phase_det, 0);
      chk(last_corr >= -6 && last_corr <= 6, "R3", last_corr, 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule